// File: doc/BRIEF.md
# Host Parallel Port Slave

This block lets an external host processor exchange bytes with a DSP through a small set of registers. The host drives a register address, a read/write select and an active-low enable strobe. It also drives an 8-bit data bus, which the block drives back only while a host read is in progress. A request output, modelled as open-drain, tells the host or a DMA engine that service is wanted. A separate active-low acknowledge input can take the place of address-based access, so that a DMA engine can move bytes without an address phase. Every host-side input is resynchronised through two flops, and all register effects occur on the cycle after the strobe is seen to deassert.

The DSP core reaches the block through a simple select/strobe port. Through it the core loads a byte for the host, takes the byte the host wrote, programs the control bits, and programs a direction register and an output register. When the port-enable bit is cleared, all fourteen host pins become general-purpose I/O and host strobes have no effect. In that mode the pins are ordered as data 0-7, address 8-10, read/write 11, enable 12 and request 13.

Top module: `hpp_slave`

## Requirements
- R1: After reset every pin output enable is low, the control word reads 0, the to-host full flag reads 0 and the from-host empty flag reads 1.
- R2: With port enable (control bit 0) clear, pinOe equals the direction register and pinOut equals the output register. A core read of the GPIO select returns the pin levels after two-flop synchronisation.
- R3: With port enable set, the data outputs pinOe[7:0] are driven only while the enable strobe (pin 12, low-active) is asserted with read/write (pin 11) high. All other pin enables except the request stay low.
- R4: A host read returns the following values. Address 0 gives status, with bit 0 the to-host full flag and bit 1 the from-host empty flag. Address 1 gives the to-host data byte. Every other address gives 0.
- R5: A host write to address 1 stores the bus value present when the strobe deasserts and clears the from-host empty flag. Writes to any other address leave the state unchanged.
- R6: A completed host read of address 1 clears the to-host full flag. The core sets it by writing select 1.
- R7: A core read of select 2 returns {5'b0, empty, data} for the from-host register and then sets the empty flag. Select 1 reads {5'b0, full, data}.
- R8: In host mode the request pin drives 0 when active and is otherwise released. It is active when (full and control bit 1) or (empty and control bit 2).
- R9: Clearing the request enable bits releases the request even when the flags stay set.
- R10: With DMA mode (control bit 3) set, the acknowledge input (low-active) replaces the enable strobe and every access targets address 1. The enable pin is ignored, and the request is released while the acknowledge is asserted.
- R11: With port enable clear, host strobes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 14 | Levels seen at the host pins |
| hostAckN | input | 1 | Host acknowledge, low-active |
| pinOut | output | 14 | Values driven onto the host pins |
| pinOe | output | 14 | Per-pin output enable |
| coreSel | input | 3 | Core register select: 0 control, 1 to-host, 2 from-host, 3 direction, 4 GPIO |
| coreWrEn | input | 1 | Core write strobe |
| coreRdEn | input | 1 | Core read strobe (pops the from-host byte when select is 2) |
| coreWdata | input | 14 | Core write data |
| coreRdata | output | 14 | Core read data for the current select |

## Verification
The assertions assume that the host holds the address, read/write and data inputs steady from strobe assertion until after the deassertion has passed through the synchroniser. They also assume that the core never writes the to-host byte in the same cycle as a host read of it completes. The directed stimulus changes pins only at the falling clock edge. It keeps the strobe low and then high for six cycles each, changes address and data only while the strobe is high, and issues core accesses only between host cycles.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int PIN_N   = DATA_W + ADDR_W + 3;
  localparam int RW_IDX  = DATA_W + ADDR_W;
  localparam int EN_IDX  = RW_IDX + 1;
  localparam int REQ_IDX = EN_IDX + 1;
  localparam int CTRL_W  = 4;

  typedef enum logic [2:0] {
    SEL_CTRL     = 3'd0,
    SEL_TOHOST   = 3'd1,
    SEL_FROMHOST = 3'd2,
    SEL_DIR      = 3'd3,
    SEL_GPIO     = 3'd4
  } hppSel_e;

  typedef struct packed {
    logic              wrDone;
    logic              rdDone;
    logic              drive;
    logic              ackAct;
    logic [ADDR_W-1:0] addr;
  } hppStrobe_t;
endpackage

// File: rtl/hpp_ctrl.sv
module hpp_ctrl
  import hpp_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_N-1:0] pinIn,
  input  logic             hostAckN,
  input  logic             portEn,
  input  logic             dmaMode,
  output logic [PIN_N-1:0] pinSync,
  output hppStrobe_t       strobes
);
  logic [PIN_N-1:0] pinStage [SYNC_N];
  logic [SYNC_N-1:0] ackStage;
  logic ackSync, strobeLvl, strobeAct, prevAct, deEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_N; i++) pinStage[i] <= '1;
      ackStage <= '1;
    end else begin
      pinStage[0] <= pinIn;
      ackStage[0] <= hostAckN;
      for (int i = 1; i < SYNC_N; i++) begin
        pinStage[i] <= pinStage[i-1];
        ackStage[i] <= ackStage[i-1];
      end
    end
  end

  assign pinSync = pinStage[SYNC_N-1];
  assign ackSync = ackStage[SYNC_N-1];

  // strobe level is high when idle (both strobes are low-active)
  assign strobeLvl = dmaMode ? ackSync : pinSync[EN_IDX];
  assign strobeAct = portEn & ~strobeLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAct <= 1'b0;
    else       prevAct <= strobeAct;
  end

  assign deEdge = portEn & prevAct & strobeLvl;

  always_comb begin
    strobes.wrDone = deEdge & ~pinSync[RW_IDX];
    strobes.rdDone = deEdge &  pinSync[RW_IDX];
    strobes.drive  = strobeAct & pinSync[RW_IDX];
    strobes.ackAct = portEn & dmaMode & ~ackSync;
    strobes.addr   = dmaMode ? ADDR_W'(1) : pinSync[RW_IDX-1:DATA_W];
  end
endmodule

// File: rtl/hpp_datapath.sv
module hpp_datapath
  import hpp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hppStrobe_t       strobes,
  input  logic [PIN_N-1:0] pinSync,
  input  hppSel_e          coreSel,
  input  logic             coreWrEn,
  input  logic             coreRdEn,
  input  logic [PIN_N-1:0] coreWdata,
  output logic [PIN_N-1:0] coreRdata,
  output logic [PIN_N-1:0] pinOut,
  output logic [PIN_N-1:0] pinOe,
  output logic             portEn,
  output logic             dmaMode,
  output logic             toHostFull,
  output logic             fromHostEmpty
);
  localparam int PAD_W = PIN_N - DATA_W - 1;

  logic [CTRL_W-1:0] ctrlReg;
  logic [PIN_N-1:0]  dirReg, gpioReg;
  logic [DATA_W-1:0] toHostData, fromHostData, hostRdData;
  logic hostWrHit, hostRdHit, corePop, coreLoad, reqOn;

  assign portEn  = ctrlReg[0];
  assign dmaMode = ctrlReg[3];

  assign hostWrHit = strobes.wrDone && (strobes.addr == ADDR_W'(1));
  assign hostRdHit = strobes.rdDone && (strobes.addr == ADDR_W'(1));
  assign coreLoad  = coreWrEn && (coreSel == SEL_TOHOST);
  assign corePop   = coreRdEn && (coreSel == SEL_FROMHOST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg       <= '0;
      dirReg        <= '0;
      gpioReg       <= '0;
      toHostData    <= '0;
      fromHostData  <= '0;
      toHostFull    <= 1'b0;
      fromHostEmpty <= 1'b1;
    end else begin
      if (coreWrEn) begin
        case (coreSel)
          SEL_CTRL:   ctrlReg    <= coreWdata[CTRL_W-1:0];
          SEL_TOHOST: toHostData <= coreWdata[DATA_W-1:0];
          SEL_DIR:    dirReg     <= coreWdata;
          SEL_GPIO:   gpioReg    <= coreWdata;
          default: ;
        endcase
      end
      if (coreLoad)       toHostFull <= 1'b1;
      else if (hostRdHit) toHostFull <= 1'b0;
      if (hostWrHit) begin
        fromHostData  <= pinSync[DATA_W-1:0];
        fromHostEmpty <= 1'b0;
      end else if (corePop) begin
        fromHostEmpty <= 1'b1;
      end
    end
  end

  always_comb begin
    case (coreSel)
      SEL_CTRL:     coreRdata = {{(PIN_N-CTRL_W){1'b0}}, ctrlReg};
      SEL_TOHOST:   coreRdata = {{PAD_W{1'b0}}, toHostFull, toHostData};
      SEL_FROMHOST: coreRdata = {{PAD_W{1'b0}}, fromHostEmpty, fromHostData};
      SEL_DIR:      coreRdata = dirReg;
      SEL_GPIO:     coreRdata = pinSync;
      default:      coreRdata = '0;
    endcase
  end

  always_comb begin
    case (strobes.addr)
      ADDR_W'(0): hostRdData = {{(DATA_W-2){1'b0}}, fromHostEmpty, toHostFull};
      ADDR_W'(1): hostRdData = toHostData;
      default:    hostRdData = '0;
    endcase
  end

  assign reqOn = portEn && !strobes.ackAct &&
                 ((toHostFull && ctrlReg[1]) || (fromHostEmpty && ctrlReg[2]));

  always_comb begin
    if (portEn) begin
      pinOut = {{(PIN_N-DATA_W){1'b0}}, hostRdData};
      pinOe  = '0;
      pinOe[DATA_W-1:0] = {DATA_W{strobes.drive}};
      pinOe[REQ_IDX]    = reqOn;
    end else begin
      pinOut = gpioReg;
      pinOe  = dirReg;
    end
  end
endmodule

// File: rtl/hpp_slave.sv
module hpp_slave
  import hpp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_N-1:0] pinIn,
  input  logic             hostAckN,
  output logic [PIN_N-1:0] pinOut,
  output logic [PIN_N-1:0] pinOe,
  input  logic [2:0]       coreSel,
  input  logic             coreWrEn,
  input  logic             coreRdEn,
  input  logic [PIN_N-1:0] coreWdata,
  output logic [PIN_N-1:0] coreRdata
);
  hppStrobe_t       strobes;
  logic [PIN_N-1:0] pinSync;
  logic             portEn, dmaMode, toHostFull, fromHostEmpty;
  hppSel_e          selE;

  assign selE = hppSel_e'(coreSel);

  hpp_ctrl #(.SYNC_N(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .hostAckN(hostAckN),
    .portEn(portEn), .dmaMode(dmaMode), .pinSync(pinSync), .strobes(strobes)
  );

  hpp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pinSync(pinSync),
    .coreSel(selE), .coreWrEn(coreWrEn), .coreRdEn(coreRdEn),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .pinOut(pinOut),
    .pinOe(pinOe), .portEn(portEn), .dmaMode(dmaMode),
    .toHostFull(toHostFull), .fromHostEmpty(fromHostEmpty)
  );
endmodule

// File: rtl/hpp_checker.sv
module hpp_checker
  import hpp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input hppStrobe_t       strobes,
  input logic             portEn,
  input logic             toHostFull,
  input logic             fromHostEmpty,
  input logic [PIN_N-1:0] pinOut,
  input logic [PIN_N-1:0] pinOe,
  input logic [2:0]       coreSel,
  input logic             coreWrEn,
  input logic             coreRdEn
);
  p_req_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    portEn |-> !pinOut[REQ_IDX]);

  p_ack_blocks_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackAct |-> !pinOe[REQ_IDX]);

  p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rstN)
    (portEn && !strobes.drive) |-> (pinOe[REQ_IDX-1:0] == '0));

  p_write_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrDone && strobes.addr == ADDR_W'(1)) |=> !fromHostEmpty);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdDone && strobes.addr == ADDR_W'(1) &&
     !(coreWrEn && coreSel == 3'd1)) |=> !toHostFull);

  p_core_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdEn && coreSel == 3'd2 &&
     !(strobes.wrDone && strobes.addr == ADDR_W'(1))) |=> fromHostEmpty);

  p_gpio_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |-> (!strobes.wrDone && !strobes.rdDone));
endmodule

bind hpp_slave hpp_checker u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .portEn(portEn),
  .toHostFull(toHostFull), .fromHostEmpty(fromHostEmpty),
  .pinOut(pinOut), .pinOe(pinOe), .coreSel(coreSel),
  .coreWrEn(coreWrEn), .coreRdEn(coreRdEn)
);

// File: tb/tb_hpp_slave.sv
module tb_hpp_slave;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] pinIn = 14'h3FFF;
  logic        hostAckN = 1'b1;
  logic [13:0] pinOut, pinOe, coreRdata, coreWdata = '0;
  logic [2:0]  coreSel = '0;
  logic        coreWrEn = 1'b0, coreRdEn = 1'b0;
  int total = 0, bad = 0;
  logic [13:0] rd;

  always #10 clk = ~clk;

  hpp_slave dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .hostAckN(hostAckN),
    .pinOut(pinOut), .pinOe(pinOe), .coreSel(coreSel), .coreWrEn(coreWrEn),
    .coreRdEn(coreRdEn), .coreWdata(coreWdata), .coreRdata(coreRdata)
  );

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic coreWrite(input logic [2:0] sel, input logic [13:0] val);
    @(negedge clk);
    coreSel = sel; coreWdata = val; coreWrEn = 1'b1;
    @(negedge clk);
    coreWrEn = 1'b0;
  endtask

  task automatic coreRead(input logic [2:0] sel, output logic [13:0] val);
    @(negedge clk);
    coreSel = sel; coreRdEn = 1'b1;
    #1 val = coreRdata;
    @(negedge clk);
    coreRdEn = 1'b0;
  endtask

  // host cycle: strobe via enable pin (useAck=0) or acknowledge (useAck=1)
  task automatic hostCycle(input bit useAck, input logic [2:0] addr, input bit rw,
                           input logic [7:0] data, output logic [13:0] oe,
                           output logic [7:0] bus);
    @(negedge clk);
    pinIn[7:0] = data; pinIn[10:8] = addr; pinIn[11] = rw;
    waitCyc(2);
    if (useAck) hostAckN = 1'b0; else pinIn[12] = 1'b0;
    waitCyc(6);
    oe = pinOe; bus = pinOut[7:0];
    if (useAck) hostAckN = 1'b1; else pinIn[12] = 1'b1;
    waitCyc(6);
  endtask

  task automatic testReset();
    check("R1 oe", pinOe, 14'h0);
    coreRead(3'd0, rd); check("R1 ctrl", rd, 14'h0);
    coreRead(3'd1, rd); check("R1 full", {13'h0, rd[8]}, 14'h0);
    coreRead(3'd2, rd); check("R1 empty", {13'h0, rd[8]}, 14'h1);
  endtask

  task automatic testGpio();
    logic [13:0] oe; logic [7:0] bus;
    coreWrite(3'd3, 14'h00FF);
    coreWrite(3'd4, 14'h2A5A);
    waitCyc(1);
    check("R2 oe", pinOe, 14'h00FF);
    check("R2 out", pinOut, 14'h2A5A);
    pinIn = 14'h1234; waitCyc(3);
    coreRead(3'd4, rd); check("R2 in", rd, 14'h1234);
    pinIn = 14'h3FFF; coreWrite(3'd3, 14'h0);
    hostCycle(0, 3'd1, 0, 8'h77, oe, bus);
    coreWrite(3'd0, 14'h1);
    coreRead(3'd2, rd); check("R11 ignored", {13'h0, rd[8]}, 14'h1);
  endtask

  task automatic testHostRw();
    logic [13:0] oe; logic [7:0] bus;
    waitCyc(1);
    check("R3 idle", pinOe, 14'h0);
    coreWrite(3'd1, 14'h00C3);
    hostCycle(0, 3'd0, 1, 8'h00, oe, bus);
    check("R3 drive", oe, 14'h00FF);
    check("R4 status", {6'h0, bus}, 14'h0003);
    hostCycle(0, 3'd1, 1, 8'h00, oe, bus);
    check("R4 data", {6'h0, bus}, 14'h00C3);
    hostCycle(0, 3'd0, 1, 8'h00, oe, bus);
    check("R6 cleared", {6'h0, bus}, 14'h0002);
    hostCycle(0, 3'd5, 1, 8'h00, oe, bus);
    check("R4 other", {6'h0, bus}, 14'h0000);
    hostCycle(0, 3'd1, 0, 8'h9E, oe, bus);
    check("R3 write no drive", oe, 14'h0);
    hostCycle(0, 3'd0, 1, 8'h00, oe, bus);
    check("R5 empty cleared", {6'h0, bus}, 14'h0000);
    coreRead(3'd2, rd); check("R7 data", rd, 14'h009E);
    coreRead(3'd2, rd); check("R7 empty set", rd, 14'h019E);
    hostCycle(0, 3'd4, 0, 8'h55, oe, bus);
    hostCycle(0, 3'd0, 1, 8'h00, oe, bus);
    check("R5 other ignored", {6'h0, bus}, 14'h0002);
  endtask

  task automatic testRequest();
    logic [13:0] oe; logic [7:0] bus;
    coreWrite(3'd0, 14'h5); waitCyc(1);
    check("R8 req on", {12'h0, pinOe[13], pinOut[13]}, 14'h2);
    hostCycle(0, 3'd1, 0, 8'h11, oe, bus);
    check("R8 req off", {13'h0, pinOe[13]}, 14'h0);
    coreRead(3'd2, rd); waitCyc(1);
    check("R8 req back", {13'h0, pinOe[13]}, 14'h1);
    coreWrite(3'd0, 14'h3); waitCyc(1);
    check("R8 full off", {13'h0, pinOe[13]}, 14'h0);
    coreWrite(3'd1, 14'h00A7); waitCyc(1);
    check("R8 full on", {13'h0, pinOe[13]}, 14'h1);
    coreWrite(3'd0, 14'h1); waitCyc(1);
    check("R9 masked", {13'h0, pinOe[13]}, 14'h0);
  endtask

  task automatic testDma();
    logic [13:0] oe; logic [7:0] bus;
    coreWrite(3'd0, 14'hB); waitCyc(1);
    check("R10 req before", {13'h0, pinOe[13]}, 14'h1);
    hostCycle(1, 3'd0, 1, 8'h00, oe, bus);
    check("R10 ack drop req", {13'h0, oe[13]}, 14'h0);
    check("R10 dma read", {6'h0, oe[7:0]}, 14'h00FF);
    check("R10 dma data", {6'h0, bus}, 14'h00A7);
    check("R10 full cleared", {13'h0, pinOe[13]}, 14'h0);
    hostCycle(1, 3'd6, 0, 8'h3C, oe, bus);
    coreRead(3'd2, rd); check("R10 dma write", rd, 14'h003C);
    hostCycle(0, 3'd1, 1, 8'h00, oe, bus);
    check("R10 enable ignored", {6'h0, oe[7:0]}, 14'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testGpio();
    testHostRw();
    testRequest();
    testDma();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule